// File: doc/BRIEF.md
# Vertical Sync Pulse Extractor

This block turns a sampled, active-low composite sync bit into a vertical sync pulse of fixed length. A saturating leaky counter stands in for an analog integrator. It counts up on every clock in which sync is asserted and loses a programmable amount on every clock in which sync is released. Narrow line-sync and equalizing pulses therefore never build up much charge. A run of broad vertical pulses lifts the counter above a programmable normal threshold. The block samples that condition at the moment sync is released, which is the edge into a serration, and starts the pulse there.

A second, higher threshold catches a vertical interval that has no serrations at all. When the counter climbs through that level, the pulse starts even though no release edge has come. The output is held by a set/reset latch. A tick prescaler with a programmable period runs while the latch is held, and a divide-by-8 counter on those ticks clears the latch. The pulse therefore lasts exactly eight tick periods. Choose the period so that eight ticks cover the whole vertical interval, about 180 µs for a 525-line signal; otherwise a later serration starts a second pulse. A one-cycle strobe marks each time the latch is set, so that field-parity logic downstream can use it as a clock enable.

Top module: `vsync_extract`

## Requirements
- R1: After synchronous reset `vsync_o` and `vsync_set_o` are low and the integrator is empty. The configuration returns to its defaults: normal level 16, default level 48, tick period 4 clocks, decay 2.
- R2: On each clock edge that samples `sync_n` low, the integrator rises by one and holds at 2^CNT_W-1. On each edge that samples it high, the integrator falls by the decay amount and stops at zero. Runs of line-sync and equalizing pulses that stay below the normal level produce no pulse.
- R3: Suppose edge k samples `sync_n` high and edge k-1 sampled it low. If the integrator value held between those edges is at or above the normal level, `vsync_o` goes high at edge k+1. Starting from an empty integrator after N low samples, that value is N.
- R4: When the integrator value goes from below the default level to at or above it, `vsync_o` goes high at the next edge, with no release edge needed. Staying at or above that level does not set it again.
- R5: Each pulse lasts exactly 8×P clock cycles, where P is the configured tick period. A period of 0 acts as 1.
- R6: `vsync_set_o` is high for exactly one cycle per pulse, in the first cycle that `vsync_o` is high.
- R7: A set request that comes while `vsync_o` is high, including its last cycle, is dropped. It neither lengthens the pulse nor starts a new one. A request after the pulse ends starts a new pulse.
- R8: With `cfg_we` high at a clock edge while `vsync_o` is low, all four configuration fields load and apply from the next cycle. While `vsync_o` is high, `cfg_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_n | input | 1 | Sampled composite sync, low while sync is asserted |
| cfg_we | input | 1 | Loads the configuration fields when the block is idle |
| cfg_lo | input | CNT_W | Normal threshold, sampled on a sync release |
| cfg_hi | input | CNT_W | Default threshold for a vertical interval without serrations |
| cfg_period | input | TICK_W | Tick period in clocks |
| cfg_decay | input | DEC_W | Integrator decrement per released clock |
| vsync_o | output | 1 | Vertical sync pulse, active high |
| vsync_set_o | output | 1 | One-cycle strobe at the start of each pulse |

## Verification
A wrong integrator value shows up as a pulse that starts on a different release edge, or one cycle off on the default crossing. It can also show up as a pulse that never appears or appears where none is due. The bench can see this within two cycles of the first broad-pulse release, so it compares both outputs every cycle against a model built from the requirements. A prescaler or divider error changes only the pulse length, so the bench measures every pulse from its rising to its falling edge. Configuration loaded at the wrong time stays hidden until the next pulse. The bench therefore runs a further default-path trigger after each attempted load and checks its length.

// File: rtl/vse_pkg.sv
`timescale 1ns/1ps
package vse_pkg;
    localparam int unsigned PULSE_TICKS = 8;
    localparam int unsigned PULSE_DIV_W = $clog2(PULSE_TICKS);

    typedef enum logic {
        LATCH_IDLE   = 1'b0,
        LATCH_ACTIVE = 1'b1
    } latch_e;
endpackage

// File: rtl/vse_integ.sv
`timescale 1ns/1ps
module vse_integ #(
    parameter int CNT_W = 10,
    parameter int DEC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic [CNT_W-1:0] thr_lo,
    input  logic [CNT_W-1:0] thr_hi,
    input  logic [DEC_W-1:0] decay,
    output logic             set_req
);
    localparam logic [CNT_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        logic             act;       // sync asserted on the previous edge
        logic             above_hi;  // default level reached on the previous edge
        logic             rel_hit;   // release edge seen with the normal level reached
        logic [CNT_W-1:0] acc;
    } integ_t;

    integ_t st_d, st_q;
    logic   hi_now;

    always_comb begin
        st_d     = st_q;
        st_d.act = ~sync_n;
        if (!sync_n) begin
            st_d.acc = (st_q.acc == ACC_MAX) ? st_q.acc : st_q.acc + 1'b1;
        end else if (st_q.acc > CNT_W'(decay)) begin
            st_d.acc = st_q.acc - CNT_W'(decay);
        end else begin
            st_d.acc = '0;
        end
        hi_now        = (st_q.acc >= thr_hi);
        st_d.above_hi = hi_now;
        st_d.rel_hit  = st_q.act & sync_n & (st_q.acc >= thr_lo);
    end

    // R3 path through the release register, R4 path on the upward crossing
    assign set_req = st_q.rel_hit | (hi_now & ~st_q.above_hi);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ACC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n && st_q.acc <= CNT_W'(decay)) |=> (st_q.acc == '0)); // R2
    AST_ACC_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && st_q.acc == ACC_MAX) |=> (st_q.acc == ACC_MAX)); // R2
    AST_RELEASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rel_hit |-> !st_q.act); // R3
endmodule

// File: rtl/vse_ticker.sv
`timescale 1ns/1ps
module vse_ticker
    import vse_pkg::*;
#(
    parameter int TICK_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TICK_W-1:0] period,
    output logic              done
);
    typedef struct packed {
        logic [TICK_W-1:0]      presc;
        logic [PULSE_DIV_W-1:0] div;
    } tick_t;

    tick_t             st_d, st_q;
    logic [TICK_W-1:0] per_m1;
    logic              last, tick;

    always_comb begin
        per_m1 = (period == '0) ? '0 : period - 1'b1;
        last   = (st_q.presc >= per_m1);
        tick   = en & last;
        done   = tick & (st_q.div == PULSE_DIV_W'(PULSE_TICKS - 1));
        st_d.presc = (!en || last) ? '0 : st_q.presc + 1'b1;
        if (!en)       st_d.div = '0;
        else if (tick) st_d.div = st_q.div + 1'b1;
        else           st_d.div = st_q.div;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICKER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.presc == '0 && st_q.div == '0)); // R5
endmodule

// File: rtl/vsync_extract.sv
`timescale 1ns/1ps
module vsync_extract
    import vse_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int TICK_W     = 12,
    parameter int DEC_W      = 4,
    parameter int DEF_LO     = 16,
    parameter int DEF_HI     = 48,
    parameter int DEF_PERIOD = 4,
    parameter int DEF_DECAY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_lo,
    input  logic [CNT_W-1:0]  cfg_hi,
    input  logic [TICK_W-1:0] cfg_period,
    input  logic [DEC_W-1:0]  cfg_decay,
    output logic              vsync_o,
    output logic              vsync_set_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  lo;
        logic [CNT_W-1:0]  hi;
        logic [TICK_W-1:0] per;
        logic [DEC_W-1:0]  dec;
        latch_e            latch;
        logic              strobe;
    } top_t;

    top_t st_d, st_q;
    logic set_req, tick_done;

    vse_integ #(.CNT_W(CNT_W), .DEC_W(DEC_W)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_n (sync_n),
        .thr_lo (st_q.lo),
        .thr_hi (st_q.hi),
        .decay  (st_q.dec),
        .set_req(set_req)
    );

    vse_ticker #(.TICK_W(TICK_W)) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (vsync_o),
        .period(st_q.per),
        .done  (tick_done)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (cfg_we && st_q.latch == LATCH_IDLE) begin // R8
            st_d.lo  = cfg_lo;
            st_d.hi  = cfg_hi;
            st_d.per = cfg_period;
            st_d.dec = cfg_decay;
        end
        case (st_q.latch)
            LATCH_IDLE: begin
                if (set_req) begin
                    st_d.latch  = LATCH_ACTIVE;
                    st_d.strobe = 1'b1;
                end
            end
            default: begin
                if (tick_done) st_d.latch = LATCH_IDLE; // R7 requests dropped here
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin // R1
            st_q.lo     <= CNT_W'(DEF_LO);
            st_q.hi     <= CNT_W'(DEF_HI);
            st_q.per    <= TICK_W'(DEF_PERIOD);
            st_q.dec    <= DEC_W'(DEF_DECAY);
            st_q.latch  <= LATCH_IDLE;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vsync_o     = (st_q.latch == LATCH_ACTIVE);
    assign vsync_set_o = st_q.strobe;

    AST_STROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_set_o |-> (vsync_o && !$past(vsync_o))); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_o |=> ($stable(st_q.lo) && $stable(st_q.hi)
                     && $stable(st_q.per) && $stable(st_q.dec))); // R8
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_o && !tick_done) |=> vsync_o); // R7
endmodule

// File: tb/sim_vsync_extract.sv
`timescale 1ns/1ps
module sim_vsync_extract;
    localparam int CW   = 10;
    localparam int TW   = 12;
    localparam int DW   = 4;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, sync_n, cfg_we;
    logic [CW-1:0] cfg_lo, cfg_hi;
    logic [TW-1:0] cfg_period;
    logic [DW-1:0] cfg_decay;
    logic          vsync_o, vsync_set_o;

    vsync_extract u0 (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .cfg_we(cfg_we),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_period(cfg_period),
        .cfg_decay(cfg_decay), .vsync_o(vsync_o), .vsync_set_o(vsync_set_o)
    );

    int    errors = 0, checks = 0, stepn = 0, cyc = 0;
    bit    finished = 0;
    string cur_req = "R1";
    // reference state
    int m_act, m_acc, m_hiq, m_samp, m_vs, m_set, m_presc, m_div;
    int m_lo, m_hi, m_per, m_dec;
    // pulse statistics seen at the ports
    int pulses, strobes, last_len, cur_len, rise_step;
    bit prev_vs;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (step %0d)", req, what, act, exp, stepn);
        end
    endtask

    task automatic model_reset();
        m_act = 0; m_acc = 0; m_hiq = 0; m_samp = 0; m_vs = 0; m_set = 0;
        m_presc = 0; m_div = 0;
        m_lo = 16; m_hi = 48; m_per = 4; m_dec = 2;
    endtask

    task automatic model_edge(int s, int we);
        int n_acc, hit, req, perm1, last, tick, done, n_samp, n_presc, n_div, n_vs, n_set;
        if (s == 0) n_acc = (m_acc == MAXV) ? MAXV : m_acc + 1;
        else        n_acc = (m_acc > m_dec) ? m_acc - m_dec : 0;
        hit    = (m_acc >= m_hi) ? 1 : 0;
        req    = (m_samp != 0 || (hit != 0 && m_hiq == 0)) ? 1 : 0;
        perm1  = (m_per == 0) ? 0 : m_per - 1;
        last   = (m_presc >= perm1) ? 1 : 0;
        tick   = (m_vs != 0 && last != 0) ? 1 : 0;
        done   = (tick != 0 && m_div == 7) ? 1 : 0;
        n_samp = (m_act != 0 && s != 0 && m_acc >= m_lo) ? 1 : 0;
        n_presc = (m_vs == 0 || last != 0) ? 0 : m_presc + 1;
        n_div  = (m_vs == 0) ? 0 : ((tick != 0) ? (m_div + 1) % 8 : m_div);
        n_vs   = (m_vs != 0) ? ((done != 0) ? 0 : 1) : req;
        n_set  = (m_vs == 0 && req != 0) ? 1 : 0;
        if (we != 0 && m_vs == 0) begin
            m_lo = int'(cfg_lo); m_hi = int'(cfg_hi);
            m_per = int'(cfg_period); m_dec = int'(cfg_decay);
        end
        m_act = (s == 0) ? 1 : 0; m_acc = n_acc; m_hiq = hit; m_samp = n_samp;
        m_presc = n_presc; m_div = n_div; m_vs = n_vs; m_set = n_set;
    endtask

    task automatic step(int s, int we);
        sync_n = s[0];
        cfg_we = we[0];
        @(posedge clk);
        model_edge(s, we);
        @(negedge clk);
        stepn++;
        check(cur_req, "vsync", int'(vsync_o), m_vs);
        check("R6", "strobe vs model", int'(vsync_set_o), m_set);
        check("R6", "strobe on rise", int'(vsync_set_o), int'(vsync_o && !prev_vs));
        if (vsync_o && !prev_vs) begin pulses++; rise_step = stepn; cur_len = 0; end
        if (vsync_o) cur_len++;
        if (!vsync_o && prev_vs) last_len = cur_len;
        if (vsync_set_o) strobes++;
        prev_vs = vsync_o;
        cfg_we = 1'b0;
    endtask

    task automatic run(int s, int n);
        for (int i = 0; i < n; i++) step(s, 0);
    endtask

    task automatic set_cfg(int lo, int hi, int per, int dec);
        cfg_lo = CW'(lo); cfg_hi = CW'(hi); cfg_period = TW'(per); cfg_decay = DW'(dec);
    endtask

    task automatic load(int s, int lo, int hi, int per, int dec);
        set_cfg(lo, hi, per, dec);
        step(s, 1);
    endtask

    task automatic clear_stats();
        pulses = 0; strobes = 0; last_len = 0; rise_step = -1;
    endtask

    task automatic hline();  run(0, 5);  run(1, 59); endtask
    task automatic eqline(); for (int i = 0; i < 2; i++) begin run(0, 2);  run(1, 30); end endtask
    task automatic brline(); for (int i = 0; i < 2; i++) begin run(0, 27); run(1, 5);  end endtask

    task automatic video_field();
        for (int i = 0; i < 4; i++) hline();
        for (int i = 0; i < 3; i++) eqline();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: cycles=%0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int b;
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0; sync_n = 1'b1; cfg_we = 1'b0;
        set_cfg(16, 48, 4, 2);
        prev_vs = 1'b0;
        clear_stats();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "vsync in reset", int'(vsync_o), 0);
        check("R1", "strobe in reset", int'(vsync_set_o), 0);
        rst_n = 1'b1;
        model_reset();

        // R1: defaults take effect (level 16, period 4 -> 32 cycles)
        cur_req = "R1";
        run(1, 10);
        clear_stats(); b = stepn;
        run(0, 16); run(1, 60);
        check("R1", "default pulses", pulses, 1);
        check("R1", "default rise step", rise_step, b + 18);
        check("R1", "default length", last_len, 32);

        // R2: sync and equalizing pulses alone give nothing
        cur_req = "R2";
        load(1, 20, 60, 30, 2);
        clear_stats();
        video_field(); video_field();
        check("R2", "no pulse on short syncs", pulses, 0);

        // R3: boundary of the normal level
        cur_req = "R3";
        load(1, 20, 200, 2, 2);
        run(1, 100);
        clear_stats();
        run(0, 19); run(1, 60);
        check("R3", "one below level", pulses, 0);
        b = stepn;
        run(0, 20); run(1, 60);
        check("R3", "at level pulses", pulses, 1);
        check("R3", "at level rise", rise_step, b + 22);
        check("R5", "period 2 length", last_len, 16);

        // R3 + R7: full vertical interval, eight ticks cover it
        cur_req = "R3";
        load(1, 20, 60, 30, 2);
        run(1, 100);
        video_field();
        clear_stats(); b = stepn;
        for (int i = 0; i < 3; i++) brline();
        for (int i = 0; i < 3; i++) eqline();
        for (int i = 0; i < 6; i++) hline();
        check("R3", "field pulses", pulses, 1);
        check("R3", "field rise", rise_step, b + 29);
        check("R5", "field length", last_len, 240);
        check("R6", "field strobes", strobes, 1);

        // R7: ticks too short give a second pulse
        cur_req = "R7";
        load(1, 20, 60, 3, 2);
        run(1, 100);
        clear_stats();
        for (int i = 0; i < 3; i++) brline();
        run(1, 200);
        check("R7", "double pulse seen", int'(pulses >= 2), 1);
        check("R6", "strobe per pulse", strobes, pulses);

        // R4 + R7 + R8: no serrations, release and load attempt inside the pulse
        cur_req = "R4";
        load(1, 20, 60, 4, 2);
        run(1, 100);
        clear_stats(); b = stepn;
        run(0, 69);
        cfg_period = TW'(1);
        step(0, 1);
        run(0, 10); run(1, 100);
        check("R4", "default path rise", rise_step, b + 61);
        check("R7", "release in pulse ignored", pulses, 1);
        check("R5", "default length", last_len, 32);
        cur_req = "R8";
        clear_stats();
        run(0, 70); run(1, 100);
        check("R8", "busy load ignored", last_len, 32);
        load(1, 20, 60, 1, 2);
        clear_stats();
        run(0, 70); run(1, 100);
        check("R8", "idle load applied", last_len, 8);
        load(1, 20, 60, 0, 2);
        clear_stats();
        run(0, 70); run(1, 100);
        check("R5", "period zero length", last_len, 8);

        // R2 + R4: saturation, one default trigger per crossing
        cur_req = "R4";
        load(1, 20, MAXV, 2, 2);
        run(1, 600);
        clear_stats(); b = stepn;
        run(0, 1200);
        check("R4", "single crossing", pulses, 1);
        check("R2", "saturated crossing rise", rise_step, b + MAXV + 1);
        run(1, 60);
        check("R2", "release after saturation", pulses, 2);

        // random runs with occasional reconfiguration
        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                int lo;
                lo = int'($urandom_range(4, 40));
                load(1, lo, lo + int'($urandom_range(1, 60)), int'($urandom_range(0, 5)),
                     int'($urandom_range(0, 4)));
            end
            run(0, int'($urandom_range(1, 70)));
            run(1, int'($urandom_range(1, 40)));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule